// File: doc/BRIEF.md
# Byte-Command I2C Master

This block is an I2C bus master that software drives one byte at a time through a small byte-wide register file. A 16-bit prescaler sets the bit rate. A control register turns the core on and enables its interrupt. A shared data location holds the byte to transmit when written and returns the last received byte when read. A shared command/status location accepts a byte-level command when written and reports the bus and transfer state when read.

Each command is a set of flag bits. The core can generate a START or repeated START, shift out one byte and sample the slave's acknowledge, shift in one byte and drive an acknowledge that software chooses, and generate a STOP. It runs whichever of these steps are flagged, in that fixed order. When the command finishes, the core raises an interrupt flag. Software clears the flag by writing the acknowledge-interrupt bit.

SCL and SDA are open drain. Each has an input pin and an output-enable pin, and an active enable pulls the line low. One SCL period lasts five prescaled ticks. The prescaler is therefore loaded with f_clk/(5·f_SCL)−1, for example 24 for 400 kHz from a 50 MHz clock.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the prescaler reads as parameter PRESC_RESET, and the control and status registers read 0x00. Both line enables and irq are low.
- R2: Offset 0 holds the low byte of the prescaler and offset 1 the high byte. Writes to them take effect only while the enable bit (bit 7 of control, offset 2) is 0. A write made while enable is 1 leaves the read-back value unchanged.
- R3: While a command runs, consecutive SCL rising edges within a byte are 5·(prescaler+1) clock cycles apart.
- R4: A command with START (command bit 7) and WRITE (bit 4) generates a START and then sends the transmit byte (offset 3) MSB first. It sets the interrupt flag after sampling the acknowledge. Status bit 7 is then 1 if the slave did not acknowledge and 0 if it did.
- R5: A WRITE command without START sends the transmit byte and delivers it intact to the addressed slave. SDA does not change while SCL is released within a data bit.
- R6: A READ command (bit 5) shifts one byte into the receive register, which reads at offset 3. The master drives NACK in the acknowledge slot if ACK (bit 3) is 1, and drives ACK if it is 0.
- R7: A STOP command (bit 6) generates a STOP condition and releases both lines. The busy bit (status bit 6) is 0 by the time the interrupt flag is set.
- R8: The busy bit is set by any START condition seen on the bus and cleared by any STOP condition, including conditions made by another master.
- R9: If the core releases SDA during a data bit but samples it low, it sets arbitration-lost (status bit 5) and the interrupt flag, releases both lines and drops the rest of the command. Arbitration-lost clears when the next command is accepted.
- R10: Transfer-in-progress (status bit 1) is 1 from acceptance of a command until its interrupt flag is set. Commands written while enable is 0 are ignored.
- R11: Writing command bit 0 clears the interrupt flag (status bit 0). irq is high only while the flag and interrupt enable (control bit 6) are both 1. Control bit 5 stores the master-mode selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid the cycle after |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the core with PRESC_RESET set to 0x00C7, a value that the reset read-back can tell apart from both zero and all-ones. At run time it writes prescaler values 3 and 6. The first keeps each byte near two hundred cycles, so many random write and read transactions against a modelled slave fit in the run. The second, together with the first, shows that the SCL period scales with the programmed value rather than being fixed. Directed cases add an address that no slave answers, a second bus driver that holds SDA low to force arbitration loss and exercise busy tracking, and commands written while the core is disabled.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter logic [15:0] PRESC_RESET = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);

  localparam logic [2:0] A_PLO = 3'd0, A_PHI = 3'd1, A_CTL = 3'd2, A_DAT = 3'd3, A_CMD = 3'd4;
  localparam logic [2:0] PH_LAST = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_STOP} state_t;

  state_t      st;
  logic [15:0] presc, cnt;
  logic        ctl_en, ctl_ien, ctl_mst;
  logic [7:0]  txd, rxd, sr;
  logic [2:0]  ph, bitn;
  logic        do_rd, do_wr, do_sto, do_nak, rbit;
  logic        st_nack, st_busy, st_al, iflag, held_scl;
  logic [1:0]  scl_sy, sda_sy;
  logic        scl_s, sda_s, sda_d;
  logic        tip, tick, accept, cmd_any, scl_low_ph;

  assign scl_s   = scl_sy[1];
  assign sda_s   = sda_sy[1];
  assign tip     = (st != S_IDLE);
  assign tick    = tip && (cnt == 16'd0);
  assign cmd_any = |reg_wdata[7:4];
  assign accept  = reg_wr && (reg_addr == A_CMD) && ctl_en && !tip && cmd_any;
  assign irq     = iflag & ctl_ien;
  assign scl_low_ph = (ph == 3'd0) || (ph == PH_LAST);

  // line synchronisers and bus condition detector
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy  <= 2'b11;
      sda_sy  <= 2'b11;
      sda_d   <= 1'b1;
      st_busy <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      sda_d  <= sda_s;
      if (scl_s && sda_d && !sda_s)      st_busy <= 1'b1;
      else if (scl_s && !sda_d && sda_s) st_busy <= 1'b0;
    end
  end

  // register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc   <= PRESC_RESET;
      ctl_en  <= 1'b0;
      ctl_ien <= 1'b0;
      ctl_mst <= 1'b0;
      txd     <= 8'h00;
    end else if (reg_wr) begin
      case (reg_addr)
        A_PLO: if (!ctl_en) presc[7:0]  <= reg_wdata;
        A_PHI: if (!ctl_en) presc[15:8] <= reg_wdata;
        A_CTL: {ctl_en, ctl_ien, ctl_mst} <= reg_wdata[7:5];
        A_DAT: txd <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= 8'h00;
    end else if (reg_rd) begin
      case (reg_addr)
        A_PLO:   reg_rdata <= presc[7:0];
        A_PHI:   reg_rdata <= presc[15:8];
        A_CTL:   reg_rdata <= {ctl_en, ctl_ien, ctl_mst, 5'b0};
        A_DAT:   reg_rdata <= rxd;
        A_CMD:   reg_rdata <= {st_nack, st_busy, st_al, 3'b0, tip, iflag};
        default: reg_rdata <= 8'h00;
      endcase
    end
  end

  // command sequencer: START -> byte -> acknowledge -> STOP, five ticks per step
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= 16'd0;
      ph       <= 3'd0;
      bitn     <= 3'd7;
      sr       <= 8'h00;
      rxd      <= 8'h00;
      rbit     <= 1'b0;
      do_rd    <= 1'b0;
      do_wr    <= 1'b0;
      do_sto   <= 1'b0;
      do_nak   <= 1'b0;
      st_nack  <= 1'b0;
      st_al    <= 1'b0;
      iflag    <= 1'b0;
      held_scl <= 1'b0;
    end else begin
      if (tip) cnt <= tick ? presc : cnt - 16'd1;
      if (reg_wr && reg_addr == A_CMD && reg_wdata[0]) iflag <= 1'b0;
      if (accept) begin
        do_sto <= reg_wdata[6];
        do_rd  <= reg_wdata[5];
        do_wr  <= reg_wdata[4];
        do_nak <= reg_wdata[3];
        sr     <= txd;
        bitn   <= 3'd7;
        ph     <= 3'd0;
        cnt    <= presc;
        iflag  <= 1'b0;
        st_al  <= 1'b0;
        if (reg_wdata[7])                     st <= S_START;
        else if (reg_wdata[5] | reg_wdata[4]) st <= S_BIT;
        else                                  st <= S_STOP;
      end else if (tick) begin
        ph <= (ph == PH_LAST) ? 3'd0 : ph + 3'd1;
        case (st)
          S_START: if (ph == PH_LAST) begin
            if (do_rd | do_wr) st <= S_BIT;
            else if (do_sto)   st <= S_STOP;
            else begin
              st       <= S_IDLE;
              iflag    <= 1'b1;
              held_scl <= 1'b1;
            end
          end
          S_BIT: begin
            if (ph == 3'd2) begin
              rbit <= sda_s;
              if (do_wr && sr[7] && !sda_s) begin
                st       <= S_IDLE;
                st_al    <= 1'b1;
                iflag    <= 1'b1;
                held_scl <= 1'b0;
              end
            end
            if (ph == PH_LAST) begin
              sr   <= {sr[6:0], rbit};
              bitn <= bitn - 3'd1;
              if (bitn == 3'd0) begin
                st <= S_ACK;
                if (do_rd) rxd <= {sr[6:0], rbit};
              end
            end
          end
          S_ACK: begin
            if (ph == 3'd2 && do_wr) st_nack <= sda_s;
            if (ph == PH_LAST) begin
              if (do_sto) st <= S_STOP;
              else begin
                st       <= S_IDLE;
                iflag    <= 1'b1;
                held_scl <= 1'b1;
              end
            end
          end
          S_STOP: if (ph == PH_LAST) begin
            st       <= S_IDLE;
            iflag    <= 1'b1;
            held_scl <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // open-drain drive per step and phase
  always_comb begin
    scl_oe = held_scl;
    sda_oe = 1'b0;
    case (st)
      S_START: begin scl_oe = scl_low_ph; sda_oe = (ph >= 3'd2); end
      S_BIT:   begin scl_oe = scl_low_ph; sda_oe = do_wr & ~sr[7]; end
      S_ACK:   begin scl_oe = scl_low_ph; sda_oe = do_rd & ~do_nak; end
      S_STOP:  begin scl_oe = (ph == 3'd0); sda_oe = (ph <= 3'd2); end
      default: ;
    endcase
  end

  AST_PRESC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) ctl_en |=> $stable(presc)); // R2
  AST_SDA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st) == S_BIT && ph inside {3'd1, 3'd2, 3'd3}) |-> $stable(sda_oe)); // R5
  AST_AL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_al) |-> (!scl_oe && !sda_oe)); // R9
  AST_TIP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) tip |-> !iflag); // R10
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $fell(tip) |-> iflag); // R10

endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  localparam logic [15:0] PRST = 16'h00C7;
  localparam logic [6:0]  SLV_ADDR = 7'h2A;

  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic s_oe = 0, rogue = 0;
  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | s_oe | rogue);

  i2c_byte_master #(.PRESC_RESET(PRST)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_w), .scl_oe(scl_oe), .sda_i(sda_w), .sda_oe(sda_oe));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;

  // slave model: 0 idle, 1 address, 2 receive, 3 transmit
  int s_mode = 0, s_cnt = 0, s_rdk = 0, s_wn = 0;
  logic [7:0] s_sr = 0;
  logic s_mack = 0, s_first = 0;
  logic [7:0] s_wbuf [0:15];

  function automatic logic [7:0] rd_pat(int k);
    logic [7:0] kk = 8'(k);
    return 8'hA5 ^ (kk * 8'd29 + 8'd3);
  endfunction

  always @(negedge sda_w) if (scl_w) begin s_mode = 1; s_cnt = -1; s_oe = 0; end
  always @(posedge sda_w) if (scl_w) begin s_mode = 0; s_oe = 0; end
  always @(posedge scl_w) if (s_mode != 0) begin
    if ((s_mode == 1 || s_mode == 2) && s_cnt >= 0 && s_cnt < 8) s_sr = {s_sr[6:0], sda_w};
    else if (s_mode == 3 && s_cnt == 8) s_mack = sda_w;
  end
  always @(negedge scl_w) if (s_mode != 0) begin
    s_cnt++;
    if (s_cnt == 8) begin
      if (s_mode == 1) begin
        if (s_sr[7:1] == SLV_ADDR) begin s_oe = 1; s_mode = s_sr[0] ? 3 : 2; s_rdk = 0; s_first = 1; end
        else begin s_mode = 0; s_oe = 0; end
      end else if (s_mode == 2) begin s_wbuf[s_wn % 16] = s_sr; s_wn++; s_oe = 1; end
      else s_oe = 0;
    end else if (s_cnt == 9) begin
      s_cnt = 0;
      if (s_mode == 3) begin
        if (s_first || !s_mack) begin
          s_sr = rd_pat(s_rdk); s_rdk++; s_first = 0; s_oe = ~s_sr[7];
        end else begin s_mode = 0; s_oe = 0; end
      end else s_oe = 0;
    end else if (s_mode == 3 && s_cnt > 0 && s_cnt < 8) s_oe = ~s_sr[7 - s_cnt];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wait_flag(input string req, output logic [7:0] s);
    int n = 0;
    s = 0;
    while (n < 5000) begin
      rd(3'd4, s);
      if (s[0]) break;
      n++;
    end
    chk(s[0] == 1'b1, req, s, 1);
  endtask

  task automatic cmd(input logic [7:0] c, input string req, output logic [7:0] s);
    wr(3'd4, c | 8'h01);
    wait_flag(req, s);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int presc_v);
    realtime t1, t2;
    logic [7:0] s;
    wr(3'd3, {SLV_ADDR, 1'b0});
    fork
      begin @(posedge scl_w); t1 = $realtime; @(posedge scl_w); t2 = $realtime; end
      wr(3'd4, 8'h91);
    join
    chk(int'((t2 - t1) / 5.0) == 5 * (presc_v + 1), "R3 scl period", int'((t2 - t1) / 5.0), 5 * (presc_v + 1));
    wait_flag("R4 address flag", s);
    chk(s[7] == 1'b0, "R4 address acked", s[7], 0);
    cmd(8'h40, "R7 stop", s);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    logic [7:0] exp_w [0:15];
    void'($urandom(32'd2024));
    idle(5);
    rst_n = 1;
    idle(2);

    // R1
    rd(3'd0, d); chk(d == PRST[7:0], "R1 presc low", d, PRST[7:0]);
    rd(3'd1, d); chk(d == PRST[15:8], "R1 presc high", d, PRST[15:8]);
    rd(3'd2, d); chk(d == 8'h00, "R1 control", d, 0);
    rd(3'd4, d); chk(d == 8'h00, "R1 status", d, 0);
    chk(!scl_oe && !sda_oe && !irq, "R1 lines and irq", {scl_oe, sda_oe, irq}, 0);

    // R2
    wr(3'd0, 8'd3); wr(3'd1, 8'd0);
    rd(3'd0, d); chk(d == 8'd3, "R2 presc write", d, 3);
    wr(3'd2, 8'hE0);
    rd(3'd2, d); chk(d == 8'hE0, "R11 control readback", d, 8'hE0);
    wr(3'd0, 8'h55);
    rd(3'd0, d); chk(d == 8'd3, "R2 locked while enabled", d, 3);

    // R10, R4, R11, R5, R7
    wr(3'd3, {SLV_ADDR, 1'b0});
    wr(3'd4, 8'h91);
    rd(3'd4, d); chk(d[1] == 1'b1, "R10 tip after accept", d[1], 1);
    wait_flag("R4 flag", s);
    chk(s[7] == 1'b0 && s[1] == 1'b0, "R4 ack and tip low", s, 0);
    chk(irq == 1'b1, "R11 irq with enable", irq, 1);
    s_wn = 0;
    wr(3'd3, 8'h3C);
    cmd(8'h10, "R5 write", s);
    cmd(8'h40, "R7 stop", s);
    chk(s[6] == 1'b0, "R7 busy clear", s[6], 0);
    chk(!scl_oe && !sda_oe, "R7 lines released", {scl_oe, sda_oe}, 0);
    chk(s_wbuf[0] == 8'h3C, "R5 byte delivered", s_wbuf[0], 8'h3C);
    wr(3'd4, 8'h01);
    rd(3'd4, d); chk(d[0] == 1'b0 && irq == 1'b0, "R11 iack clears", {d[0], irq}, 0);

    // random write then read transactions
    for (int t = 0; t < 6; t++) begin
      int n = 1 + int'($urandom % 4);
      s_wn = 0;
      wr(3'd3, {SLV_ADDR, 1'b0});
      cmd(8'h90, "R4 start write", s);
      chk(s[7] == 1'b0, "R4 ack random", s[7], 0);
      for (int i = 0; i < n; i++) begin
        exp_w[i] = 8'($urandom);
        wr(3'd3, exp_w[i]);
        cmd(8'h10, "R5 write random", s);
      end
      cmd(8'h40, "R7 stop random", s);
      chk(s[6] == 1'b0, "R7 busy clear random", s[6], 0);
      for (int i = 0; i < n; i++)
        chk(s_wbuf[i] == exp_w[i], "R5 data random", s_wbuf[i], exp_w[i]);
      wr(3'd3, {SLV_ADDR, 1'b1});
      cmd(8'h90, "R4 start read", s);
      for (int k = 0; k < n; k++) begin
        cmd((k == n - 1) ? 8'h28 : 8'h20, "R6 read", s);
        rd(3'd3, d);
        chk(d == rd_pat(k), "R6 read data", d, rd_pat(k));
        chk(s_mack == (k == n - 1), "R6 master ack choice", s_mack, (k == n - 1));
      end
      cmd(8'h40, "R7 stop read", s);
    end

    // R4 no slave at address
    wr(3'd3, {7'h11, 1'b0});
    cmd(8'h90, "R4 nack flag", s);
    chk(s[7] == 1'b1, "R4 nack reported", s[7], 1);
    cmd(8'h40, "R7 stop after nack", s);

    // R3 second prescaler value
    measure(3);
    wr(3'd2, 8'h60); wr(3'd0, 8'd6); wr(3'd2, 8'hE0);
    measure(6);

    // R11 interrupt disabled
    wr(3'd2, 8'hA0);
    wr(3'd3, {SLV_ADDR, 1'b0});
    cmd(8'h90, "R11 flag without irq", s);
    chk(irq == 1'b0, "R11 irq masked", irq, 0);
    cmd(8'h40, "R7 stop", s);

    // R10 disabled core ignores commands
    wr(3'd2, 8'h20);
    wr(3'd4, 8'h01);
    wr(3'd4, 8'h90);
    idle(60);
    rd(3'd4, d);
    chk(d[1] == 1'b0 && d[0] == 1'b0 && !scl_oe, "R10 ignored when disabled", d, 0);

    // R8, R9
    wr(3'd2, 8'hE0);
    rogue = 1;
    idle(10);
    rd(3'd4, d); chk(d[6] == 1'b1, "R8 busy from other master", d[6], 1);
    wr(3'd3, 8'hFF);
    cmd(8'h90, "R9 flag on loss", s);
    chk(s[5] == 1'b1 && s[1] == 1'b0, "R9 arbitration lost", s, 8'h21);
    chk(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);
    rogue = 0;
    idle(10);
    rd(3'd4, d); chk(d[6] == 1'b0, "R8 busy cleared by stop", d[6], 1'b0);
    wr(3'd3, {SLV_ADDR, 1'b0});
    cmd(8'h90, "R9 recovery", s);
    chk(s[5] == 1'b0 && s[7] == 1'b0, "R9 lost bit cleared", s, 0);
    cmd(8'h40, "R7 final stop", s);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule